// File: doc/BRIEF.md
# Descriptor Staging and Commit Port

This block receives an extended transfer descriptor as eight 32-bit words through a simple register write port. Each word has a fixed word offset. Word 7 is the control word. Words 0 to 6 are kept in staging registers and can be written in any order; a later write to the same offset replaces the earlier one. A write to the control word with bit 31 set is the commit. It pushes the seven staged words and the control word being written into a descriptor FIFO as one entry, in the same clock cycle. A control-word write with bit 31 clear pushes nothing.

Toward the downstream mover, the block shows the oldest FIFO entry already split into named fields. The mover removes that entry with a one-cycle pop strobe. The writer polls the full flag and waits before it commits. A commit made while the FIFO is full is dropped and sets a sticky overflow flag. The block also reports an empty flag and a 16-bit fill level.

Top module: `dcp_commit_port`

## Requirements
- R1: After reset: q_empty=1, q_full=0, q_level=0, q_overflow=0.
- R2: A write with cfg_word 0..6 updates only that staged word, and the last write to an offset wins. The word offsets are: 0 read address low, 1 write address low, 2 length, 3 burst/sequence, 4 stride, 5 read address high, 6 write address high.
- R3: A write at offset 7 with bit 31 of cfg_wdata set, while q_full=0, pushes one entry. The entry holds the staged words 0..6 plus cfg_wdata as word 7. q_level rises by one after that clock edge.
- R4: A write at offset 7 with bit 31 clear pushes nothing and leaves q_level unchanged.
- R5: Staged words keep their values after a commit, so a second commit repeats every word that was not rewritten.
- R6: Entries leave in commit order. q_pop with q_empty=0 removes the head entry. q_pop while empty is ignored.
- R7: q_full=1 exactly when q_level equals DEPTH (default 8). A commit while q_full=1 is dropped, even if q_pop is high in the same cycle, and sets q_overflow. q_overflow stays set until reset.
- R8: The head's word 3 is split as follows: write burst in bits 31:24, read burst in bits 23:16, sequence number in bits 15:0. A burst field of 0 is reported as MAX_BURST (default 256).
- R9: The head's word 4 is split into a write stride (bits 31:16) and a read stride (bits 15:0).
- R10: The head's word 7 is split as follows: channel in bits 7:0, d_flags[i] = bit 8+i for i=0..7, error mask in bits 23:16, early-done in bit 24.
- R11: The head's read address is {word 5, word 0}, its write address is {word 6, word 1}, and its length is word 2.
- R12: A commit and a pop in the same cycle, with the FIFO neither full nor empty, both take effect and q_level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Word write strobe |
| cfg_word | input | 3 | Word offset of the write |
| cfg_wdata | input | 32 | Write data |
| q_pop | input | 1 | Remove the head entry |
| q_full | output | 1 | FIFO holds DEPTH entries |
| q_empty | output | 1 | FIFO holds no entry |
| q_level | output | 16 | Number of entries held |
| q_overflow | output | 1 | Sticky: a commit was dropped |
| d_rd_addr | output | 64 | Head read address |
| d_wr_addr | output | 64 | Head write address |
| d_len | output | 32 | Head length in bytes |
| d_wr_burst | output | BURST_W (9) | Head write burst, 0 mapped to MAX_BURST |
| d_rd_burst | output | BURST_W (9) | Head read burst, 0 mapped to MAX_BURST |
| d_seq | output | 16 | Head sequence number |
| d_wr_stride | output | 16 | Head write stride |
| d_rd_stride | output | 16 | Head read stride |
| d_chan | output | 8 | Head channel |
| d_flags | output | 8 | Head control flags (control bits 15:8) |
| d_err_mask | output | 8 | Head error mask |
| d_early_done | output | 1 | Head early-done bit |

## Verification
Every result is due at the first rising edge that samples the stimulus. That edge updates the staging registers, the FIFO pointers, the level counter and the overflow flag. The full and empty flags, the fill level and the unpacked head fields follow combinationally from those registers. The bench drives inputs on the falling edge and samples 2 ns after the next rising edge, so each check sees exactly one edge's worth of change. The field checks read the head before the pop that removes it.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 8;
  localparam int OFF_W   = 3;
  localparam int CTL_IDX = 7;
  localparam int GO_BIT  = 31;
  localparam int ENTRY_W = WORD_W * N_WORDS;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] desc_words_t;
endpackage

// File: rtl/dcp_stage.sv
module dcp_stage
  import dcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFF_W-1:0]  word,
  input  logic [WORD_W-1:0] wdata,
  output logic              commit_o,
  output desc_words_t       entry_o
);
  // Words 0..6 are held; the control word is taken straight from the bus.
  for (genvar i = 0; i < N_WORDS - 1; i++) begin : g_word
    logic              en;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] q;

    assign en = we && (word == OFF_W'(i));

    always_comb begin
      d = q;
      if (en) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign entry_o[i] = q;
  end

  assign entry_o[CTL_IDX] = wdata;
  assign commit_o = we && (word == OFF_W'(CTL_IDX)) && wdata[GO_BIT];
endmodule

// File: rtl/dcp_fifo.sv
module dcp_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = wrap_inc(wr_ptr_q);
    if (do_pop)  rd_ptr_d = wrap_inc(rd_ptr_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
    ovf_d = ovf_q | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/dcp_unpack.sv
module dcp_unpack
  import dcp_pkg::*;
#(
  parameter int MAX_BURST = 256,
  localparam int BW       = $clog2(MAX_BURST + 1)
) (
  input  desc_words_t   words,
  output logic [63:0]   rd_addr,
  output logic [63:0]   wr_addr,
  output logic [31:0]   len,
  output logic [BW-1:0] wr_burst,
  output logic [BW-1:0] rd_burst,
  output logic [15:0]   seq,
  output logic [15:0]   wr_stride,
  output logic [15:0]   rd_stride,
  output logic [7:0]    chan,
  output logic [7:0]    flags,
  output logic [7:0]    err_mask,
  output logic          early_done
);
  function automatic logic [BW-1:0] burst_eff(input logic [7:0] raw);
    return (raw == 8'd0) ? BW'(MAX_BURST) : BW'(raw);
  endfunction

  assign rd_addr    = {words[5], words[0]};
  assign wr_addr    = {words[6], words[1]};
  assign len        = words[2];
  assign wr_burst   = burst_eff(words[3][31:24]);
  assign rd_burst   = burst_eff(words[3][23:16]);
  assign seq        = words[3][15:0];
  assign wr_stride  = words[4][31:16];
  assign rd_stride  = words[4][15:0];
  assign chan       = words[CTL_IDX][7:0];
  assign flags      = words[CTL_IDX][15:8];
  assign err_mask   = words[CTL_IDX][23:16];
  assign early_done = words[CTL_IDX][24];
endmodule

// File: rtl/dcp_commit_port.sv
module dcp_commit_port
  import dcp_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int MAX_BURST = 256,
  localparam int BURST_W  = $clog2(MAX_BURST + 1),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_word,
  input  logic [31:0]        cfg_wdata,
  input  logic               q_pop,
  output logic               q_full,
  output logic               q_empty,
  output logic [15:0]        q_level,
  output logic               q_overflow,
  output logic [63:0]        d_rd_addr,
  output logic [63:0]        d_wr_addr,
  output logic [31:0]        d_len,
  output logic [BURST_W-1:0] d_wr_burst,
  output logic [BURST_W-1:0] d_rd_burst,
  output logic [15:0]        d_seq,
  output logic [15:0]        d_wr_stride,
  output logic [15:0]        d_rd_stride,
  output logic [7:0]         d_chan,
  output logic [7:0]         d_flags,
  output logic [7:0]         d_err_mask,
  output logic               d_early_done
);
  logic          commit;
  desc_words_t   entry_in, entry_head;
  logic [CW-1:0] count;

  dcp_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .word     (cfg_word),
    .wdata    (cfg_wdata),
    .commit_o (commit),
    .entry_o  (entry_in)
  );

  dcp_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (commit),
    .din   (entry_in),
    .pop   (q_pop),
    .dout  (entry_head),
    .full  (q_full),
    .empty (q_empty),
    .count (count),
    .ovf   (q_overflow)
  );

  assign q_level = 16'(count);

  dcp_unpack #(.MAX_BURST(MAX_BURST)) u_unpack (
    .words      (entry_head),
    .rd_addr    (d_rd_addr),
    .wr_addr    (d_wr_addr),
    .len        (d_len),
    .wr_burst   (d_wr_burst),
    .rd_burst   (d_rd_burst),
    .seq        (d_seq),
    .wr_stride  (d_wr_stride),
    .rd_stride  (d_rd_stride),
    .chan       (d_chan),
    .flags      (d_flags),
    .err_mask   (d_err_mask),
    .early_done (d_early_done)
  );
endmodule

// File: rtl/dcp_commit_port_chk.sv
module dcp_commit_port_chk #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [2:0]  cfg_word,
  input logic        go_bit,
  input logic        q_pop,
  input logic        q_full,
  input logic        q_empty,
  input logic [15:0] q_level,
  input logic        q_overflow
);
  logic ctl_wr, go;
  assign ctl_wr = cfg_we && (cfg_word == 3'd7);
  assign go     = ctl_wr && go_bit;

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= 16'(DEPTH));

  // R3
  go_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !q_full && !q_pop |=> q_level == $past(q_level) + 16'd1);

  // R4
  nogo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !go_bit && !q_pop |=> $stable(q_level));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && q_full && !q_pop |=> $stable(q_level) && q_overflow);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |=> q_overflow);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty && !go |=> q_empty);

  // R12
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && q_pop && !q_full && !q_empty |=> $stable(q_level));
endmodule

bind dcp_commit_port dcp_commit_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_word   (cfg_word),
  .go_bit     (cfg_wdata[31]),
  .q_pop      (q_pop),
  .q_full     (q_full),
  .q_empty    (q_empty),
  .q_level    (q_level),
  .q_overflow (q_overflow)
);

// File: tb/dcp_commit_port_bench.sv
module dcp_commit_port_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_word;
  logic [31:0] cfg_wdata;
  logic        q_pop;
  logic        q_full, q_empty, q_overflow, d_early_done;
  logic [15:0] q_level, d_seq, d_wr_stride, d_rd_stride;
  logic [63:0] d_rd_addr, d_wr_addr;
  logic [31:0] d_len;
  logic [8:0]  d_wr_burst, d_rd_burst;
  logic [7:0]  d_chan, d_flags, d_err_mask;

  int checks   = 0;
  int failures = 0;

  dcp_commit_port u_dcp_commit_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .q_pop(q_pop), .q_full(q_full), .q_empty(q_empty),
    .q_level(q_level), .q_overflow(q_overflow), .d_rd_addr(d_rd_addr),
    .d_wr_addr(d_wr_addr), .d_len(d_len), .d_wr_burst(d_wr_burst),
    .d_rd_burst(d_rd_burst), .d_seq(d_seq), .d_wr_stride(d_wr_stride),
    .d_rd_stride(d_rd_stride), .d_chan(d_chan), .d_flags(d_flags),
    .d_err_mask(d_err_mask), .d_early_done(d_early_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [2:0]  off;
    logic [31:0] data;
    logic        pop;
    logic [15:0] exp_level;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 32'h0000_A000, 1'b0, 16'd0}, // R2 staging only
    '{1'b1, 3'd7, 32'h0000_0000, 1'b0, 16'd0}, // R4 go clear
    '{1'b1, 3'd7, 32'h8000_0000, 1'b0, 16'd1}, // R3 commit
    '{1'b1, 3'd7, 32'h8000_0001, 1'b0, 16'd2}, // R5 recommit
    '{1'b0, 3'd0, 32'h0000_0000, 1'b1, 16'd1}, // R6 pop
    '{1'b1, 3'd7, 32'h8000_0002, 1'b1, 16'd1}, // R12 push+pop
    '{1'b0, 3'd0, 32'h0000_0000, 1'b1, 16'd0}, // R6 pop
    '{1'b0, 3'd0, 32'h0000_0000, 1'b1, 16'd0}  // R6 pop on empty
  };

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] off,
                      input logic [31:0] data, input logic pop);
    @(negedge clk);
    cfg_we = we; cfg_word = off; cfg_wdata = data; q_pop = pop;
    @(posedge clk);
    #2;
    cfg_we = 1'b0; q_pop = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0; cfg_wdata = '0; q_pop = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(q_empty == 1'b1 && q_full == 1'b0, "R1 flags",
          {62'd0, q_empty, q_full}, 64'h2);
    check(q_level == 16'd0 && q_overflow == 1'b0, "R1 level",
          {47'd0, q_overflow, q_level}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 staged in reverse order, offset 2 rewritten (last wins)
    step(1'b1, 3'd2, 32'hDEAD_BEEF, 1'b0);
    step(1'b1, 3'd6, 32'h0000_0007, 1'b0);
    step(1'b1, 3'd5, 32'h0000_0003, 1'b0);
    step(1'b1, 3'd4, 32'h0001_0000, 1'b0);
    step(1'b1, 3'd3, 32'h1020_0005, 1'b0);
    step(1'b1, 3'd2, 32'h0000_0400, 1'b0);
    step(1'b1, 3'd1, 32'h2000_0080, 1'b0);
    step(1'b1, 3'd0, 32'h1000_0040, 1'b0);
    check(q_empty == 1'b1, "R2 no push from staging", {63'd0, q_empty}, 64'h1);
    step(1'b1, 3'd7, 32'h81AB_C312, 1'b0);
    check(q_level == 16'd1, "R3 level after commit", {48'd0, q_level}, 64'h1);
    // R11
    check(d_rd_addr == 64'h0000_0003_1000_0040, "R11 rd addr", d_rd_addr, 64'h0000_0003_1000_0040);
    check(d_wr_addr == 64'h0000_0007_2000_0080, "R11 wr addr", d_wr_addr, 64'h0000_0007_2000_0080);
    check(d_len == 32'h400, "R2 R11 len last write wins", {32'd0, d_len}, 64'h400);
    // R8
    check(d_wr_burst == 9'h10 && d_rd_burst == 9'h20, "R8 bursts",
          {46'd0, d_wr_burst, d_rd_burst}, {46'd0, 9'h10, 9'h20});
    check(d_seq == 16'd5, "R8 seq", {48'd0, d_seq}, 64'd5);
    // R9
    check(d_wr_stride == 16'd1 && d_rd_stride == 16'd0, "R9 strides",
          {32'd0, d_wr_stride, d_rd_stride}, 64'h0001_0000);
    // R10
    check(d_chan == 8'h12 && d_flags == 8'hC3, "R10 chan flags",
          {48'd0, d_chan, d_flags}, 64'h12C3);
    check(d_err_mask == 8'hAB && d_early_done == 1'b1, "R10 mask early",
          {55'd0, d_early_done, d_err_mask}, 64'h1AB);

    // R5 second commit reuses staged words; R8 zero bursts
    step(1'b1, 3'd3, 32'h0000_0009, 1'b0);
    step(1'b1, 3'd7, 32'h8000_0000, 1'b0);
    step(1'b0, 3'd0, 32'h0, 1'b1);
    check(d_seq == 16'd9, "R6 head after pop", {48'd0, d_seq}, 64'd9);
    check(d_wr_burst == 9'd256 && d_rd_burst == 9'd256, "R8 zero burst max",
          {46'd0, d_wr_burst, d_rd_burst}, {46'd0, 9'd256, 9'd256});
    check(d_rd_addr == 64'h0000_0003_1000_0040 && d_len == 32'h400, "R5 retained words",
          d_rd_addr, 64'h0000_0003_1000_0040);
    check(d_chan == 8'h00 && d_early_done == 1'b0, "R10 new control",
          {55'd0, d_early_done, d_chan}, 64'h0);
    step(1'b0, 3'd0, 32'h0, 1'b1);
    check(q_empty == 1'b1, "R6 empty after pops", {63'd0, q_empty}, 64'h1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].off, VEC[i].data, VEC[i].pop);
      check(q_level == VEC[i].exp_level, $sformatf("R3 R4 R6 R12 vector %0d level", i),
            {48'd0, q_level}, {48'd0, VEC[i].exp_level});
    end
    check(q_overflow == 1'b0, "R7 no overflow yet", {63'd0, q_overflow}, 64'h0);

    // R7 fill to full
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 3'd3, 32'(i), 1'b0);
      step(1'b1, 3'd7, 32'h8000_0000, 1'b0);
    end
    check(q_level == 16'd8 && q_full == 1'b1, "R7 full at depth",
          {47'd0, q_full, q_level}, {47'd0, 1'b1, 16'd8});
    step(1'b1, 3'd3, 32'd99, 1'b0);
    step(1'b1, 3'd7, 32'h8000_0000, 1'b0);
    check(q_level == 16'd8 && q_overflow == 1'b1, "R7 drop sets overflow",
          {47'd0, q_overflow, q_level}, {47'd0, 1'b1, 16'd8});
    step(1'b1, 3'd7, 32'h8000_0000, 1'b1);
    check(q_level == 16'd7 && q_full == 1'b0, "R7 commit dropped during pop when full",
          {47'd0, q_full, q_level}, {47'd0, 1'b0, 16'd7});
    for (int i = 1; i < 8; i++) begin
      check(d_seq == 16'(i), "R6 order", {48'd0, d_seq}, 64'(i));
      step(1'b0, 3'd0, 32'h0, 1'b1);
    end
    check(q_empty == 1'b1 && q_overflow == 1'b1, "R7 overflow sticky, dropped absent",
          {62'd0, q_empty, q_overflow}, 64'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule